// File: doc/BRIEF.md
# CAN Bus Join and Shutdown Sequencer

This block decides when a CAN protocol engine is attached to the bus and when it is held in reset. Two software controls feed it: a reset request and a forced-reset request. While either is set, the engine sits in a reset state. In that state the mode-configuration bits may be written, and transmission is blocked. When both controls are clear, the block watches the sampled bus level. After a run of eleven recessive bits in a row, it attaches the engine. Attaching raises the bus-connected flag, starts the timestamp counter and enables all transmit slots.

Shutdown has two paths, and the path depends on the engine's condition when the reset request arrives.

- **Normal operation.** The block records which transmit slots already hold a pending request. Only those recorded slots may still send. The receive path stays enabled. Once every recorded request has completed and the bus is idle, the engine drops into reset.
- **Bus-off.** The block counts 128 separate eleven-bit recessive runs before it reaches reset.

Each entry into reset gives a single-cycle pulse. That pulse zeroes the timestamp counter and both error counters.

Top module: `can_join_seq`

## Requirements
- R1: After `rst_n` is released with a stop request (`sw_reset` or `force_reset`) present, the outputs are: `in_reset`=1, `cfg_we`=1, `tx_block`=1, `bus_on`=0, `ts_en`=0, `rx_en`=0, `tx_slot_en`=0.
- R2: Once both stop requests are 0, `in_reset` drops on the next cycle. `bus_on` and `ts_en` then rise in the cycle after the `bit_tick` that samples the 11th consecutive recessive level (`rx_level`=1 means recessive).
- R3: A dominant sample (`rx_level`=0 with `bit_tick`) restarts the recessive run from zero. Bits sampled after joining have no effect on `bus_on`.
- R4: The block leaves reset only when `sw_reset` and `force_reset` are both 0. Either one alone keeps it in reset whatever the bus level.
- R5: A stop request while attached and not bus-off starts shutdown. During shutdown, `tx_slot_en` equals the `tx_pend` bits captured at the request, minus any that have since cleared. Slots that become pending later are never enabled. Reset is entered only after all captured bits are 0 and `bus_idle`=1.
- R6: During shutdown, `rx_en` and `bus_on` stay 1. Both go to 0 in reset.
- R7: A stop request while `bus_off`=1 enters recovery. `in_reset` rises only after 128 eleven-bit recessive runs. A dominant sample restarts the current run but keeps the completed-run count.
- R8: `cnt_clr` is a pulse exactly one cycle long, given in the same cycle in which `in_reset` first reads 1.
- R9: `tx_block` is 1 from the cycle after a stop request is taken while attached, until and throughout reset. It is 0 while attached with no stop request.
- R10: `cfg_we` is 1 only while `in_reset` is 1. Otherwise mode writes are refused.
- R11: While attached with no stop request, `tx_slot_en` is all ones. While joining or in reset, it is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each bus bit sample point |
| rx_level | input | 1 | Sampled bus level, 1 = recessive |
| sw_reset | input | 1 | Software reset request |
| force_reset | input | 1 | Forced reset request |
| bus_off | input | 1 | Engine is in bus-off |
| tx_pend | input | SLOTS | Per-slot pending transmit request |
| bus_idle | input | 1 | No frame in progress on the bus |
| in_reset | output | 1 | Reset-state status |
| bus_on | output | 1 | Engine attached to the bus |
| ts_en | output | 1 | Timestamp counter enable |
| rx_en | output | 1 | Receive path enable |
| cnt_clr | output | 1 | One-cycle clear of timestamp and error counters |
| tx_block | output | 1 | Refuse new transmit requests |
| tx_slot_en | output | SLOTS | Slots allowed to transmit |
| cfg_we | output | 1 | Mode-bit write enable |

## Verification
The join detector is tested with a table of bit patterns:

- a clean run of eleven recessive bits, and one of only ten;
- a dominant bit early in the run, and one just before the eleventh bit;
- a pattern that joins and then keeps feeding bits.

Together these separate a correct consecutive-run count from an off-by-one count, from a count that ignores dominant bits, and from a count that restarts too late.

The shutdown test raises a new pending request after capture, then holds the bus busy after the captured requests clear. This shows whether the block waits only for the captured slots and for idle. The bus-off test interrupts one run mid-way and stops one run short of 128. This tells a completed-run count apart from a raw recessive-bit count.

// File: rtl/cjs_pkg.sv
package cjs_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_JOINING = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_DRAIN   = 3'd3,
    ST_RECOVER = 3'd4
  } seq_state_t;

  // Any stop request keeps the engine off the bus.
  function automatic logic stop_req(input logic sw, input logic forced);
    return sw | forced;
  endfunction
endpackage

// File: rtl/cjs_run_counter.sv
module cjs_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic recessive,
  output logic run_done
);
  localparam int W = $clog2(RUN_LEN + 1);
  localparam logic [W-1:0] LAST = W'(RUN_LEN - 1);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic rec);
    if (!rec) return '0;
    if (c == LAST) return '0;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= next_cnt(cnt, recessive);
  end

  assign run_done = en & tick & recessive & (cnt == LAST);
endmodule

// File: rtl/cjs_recovery_counter.sv
module cjs_recovery_counter #(
  parameter int RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic run_done,
  output logic rec_done
);
  localparam int W = $clog2(RUNS + 1);
  localparam logic [W-1:0] MAXC = W'(RUNS);
  localparam logic [W-1:0] PRE  = W'(RUNS - 1);

  logic [W-1:0] runs;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] c);
    return (c == MAXC) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         runs <= '0;
    else if (!en)       runs <= '0;
    else if (run_done)  runs <= sat_inc(runs);
  end

  assign rec_done = en & run_done & (runs == PRE);
endmodule

// File: rtl/cjs_ctrl_fsm.sv
module cjs_ctrl_fsm
  import cjs_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             bus_off,
  input  logic             bus_idle,
  input  logic [SLOTS-1:0] tx_pend,
  input  logic             run_done,
  input  logic             rec_done,
  output logic             run_en,
  output logic             rec_en,
  output logic             in_reset,
  output logic             bus_on,
  output logic             ts_en,
  output logic             rx_en,
  output logic             cnt_clr,
  output logic             tx_block,
  output logic [SLOTS-1:0] tx_slot_en,
  output logic             cfg_we
);
  seq_state_t state, nxt;
  logic [SLOTS-1:0] kept;
  logic drained;

  assign drained = ((kept & tx_pend) == '0) & bus_idle;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:   if (!stop) nxt = ST_JOINING;
      ST_JOINING: if (stop) nxt = ST_RESET;
                  else if (run_done) nxt = ST_ACTIVE;
      ST_ACTIVE:  if (stop) nxt = bus_off ? ST_RECOVER : ST_DRAIN;
      ST_DRAIN:   if (bus_off) nxt = ST_RECOVER;
                  else if (drained) nxt = ST_RESET;
      ST_RECOVER: if (rec_done) nxt = ST_RESET;
      default:    nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RESET;
      kept    <= '0;
      cnt_clr <= 1'b0;
    end else begin
      state   <= nxt;
      cnt_clr <= (nxt == ST_RESET) && (state != ST_RESET);
      if (state == ST_ACTIVE && stop) kept <= tx_pend;
      else if (state == ST_DRAIN)     kept <= kept & tx_pend;
      else                            kept <= '0;
    end
  end

  assign run_en     = (state == ST_JOINING) || (state == ST_RECOVER);
  assign rec_en     = (state == ST_RECOVER);
  assign in_reset   = (state == ST_RESET);
  assign cfg_we     = (state == ST_RESET);
  assign bus_on     = (state == ST_ACTIVE) || (state == ST_DRAIN);
  assign rx_en      = bus_on;
  assign ts_en      = bus_on || (state == ST_RECOVER);
  assign tx_block   = (state == ST_RESET) || (state == ST_DRAIN) || (state == ST_RECOVER);
  assign tx_slot_en = (state == ST_ACTIVE) ? '1 :
                      (state == ST_DRAIN)  ? (kept & tx_pend) : '0;
endmodule

// File: rtl/can_join_seq.sv
module can_join_seq
  import cjs_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int RUN_LEN = 11,
  parameter int RUNS    = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_level,
  input  logic             sw_reset,
  input  logic             force_reset,
  input  logic             bus_off,
  input  logic [SLOTS-1:0] tx_pend,
  input  logic             bus_idle,
  output logic             in_reset,
  output logic             bus_on,
  output logic             ts_en,
  output logic             rx_en,
  output logic             cnt_clr,
  output logic             tx_block,
  output logic [SLOTS-1:0] tx_slot_en,
  output logic             cfg_we
);
  logic stop, run_en, rec_en, run_done, rec_done;

  assign stop = stop_req(sw_reset, force_reset);

  cjs_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(bit_tick),
    .recessive(rx_level), .run_done(run_done)
  );

  cjs_recovery_counter #(.RUNS(RUNS)) u_rec (
    .clk(clk), .rst_n(rst_n), .en(rec_en), .run_done(run_done),
    .rec_done(rec_done)
  );

  cjs_ctrl_fsm #(.SLOTS(SLOTS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .stop(stop), .bus_off(bus_off),
    .bus_idle(bus_idle), .tx_pend(tx_pend), .run_done(run_done),
    .rec_done(rec_done), .run_en(run_en), .rec_en(rec_en),
    .in_reset(in_reset), .bus_on(bus_on), .ts_en(ts_en), .rx_en(rx_en),
    .cnt_clr(cnt_clr), .tx_block(tx_block), .tx_slot_en(tx_slot_en),
    .cfg_we(cfg_we)
  );
endmodule

// File: rtl/cjs_checker.sv
module cjs_checker #(
  parameter int SLOTS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_reset,
  input logic             force_reset,
  input logic             in_reset,
  input logic             bus_on,
  input logic             rx_en,
  input logic             cnt_clr,
  input logic             tx_block,
  input logic [SLOTS-1:0] tx_slot_en,
  input logic             cfg_we,
  input logic             run_done,
  input logic             rec_done
);
  // R8
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !cnt_clr);
  // R8
  clr_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> (in_reset && !$past(in_reset)));
  // R2
  join_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_on) |-> $past(run_done));
  // R4
  leave_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset) |-> $past(!sw_reset && !force_reset));
  // R9
  block_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |-> (tx_block && tx_slot_en == '0));
  // R5
  no_new_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_block) && tx_block) |-> ((tx_slot_en & ~$past(tx_slot_en)) == '0));
  // R7
  recover_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> in_reset);
  // R10
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !bus_on);
  // R6
  rx_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |-> !rx_en);
endmodule

bind can_join_seq cjs_checker #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .force_reset(force_reset),
  .in_reset(in_reset), .bus_on(bus_on), .rx_en(rx_en), .cnt_clr(cnt_clr),
  .tx_block(tx_block), .tx_slot_en(tx_slot_en), .cfg_we(cfg_we),
  .run_done(run_done), .rec_done(rec_done)
);

// File: tb/can_join_seq_bench.sv
module can_join_seq_bench;
  localparam int SLOTS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, rx_level = 1'b1;
  logic sw_reset = 1'b1, force_reset = 1'b0, bus_off = 1'b0, bus_idle = 1'b1;
  logic [SLOTS-1:0] tx_pend = '0;
  logic in_reset, bus_on, ts_en, rx_en, cnt_clr, tx_block, cfg_we;
  logic [SLOTS-1:0] tx_slot_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_join_seq #(.SLOTS(SLOTS)) u_can_join_seq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_level(rx_level),
    .sw_reset(sw_reset), .force_reset(force_reset), .bus_off(bus_off),
    .tx_pend(tx_pend), .bus_idle(bus_idle), .in_reset(in_reset),
    .bus_on(bus_on), .ts_en(ts_en), .rx_en(rx_en), .cnt_clr(cnt_clr),
    .tx_block(tx_block), .tx_slot_en(tx_slot_en), .cfg_we(cfg_we)
  );

  // {expected join, bit count, pattern LSB first, 1 = recessive}
  localparam logic [21:0] VEC [6] = '{
    {1'b1, 5'd11, 16'h07FF},
    {1'b0, 5'd10, 16'h03FF},
    {1'b0, 5'd16, 16'hFFDF},
    {1'b1, 5'd12, 16'h0FFE},
    {1'b0, 5'd16, 16'hFBFF},
    {1'b1, 5'd16, 16'hFFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1; rx_level = lvl;
      @(negedge clk); bit_tick = 1'b0; rx_level = 1'b1;
    end
  endtask

  task automatic go_reset();
    @(negedge clk);
    tx_pend = '0; bus_idle = 1'b1; bus_off = 1'b0; sw_reset = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic join_bus();
    go_reset();
    sw_reset = 1'b0; force_reset = 1'b0;
    @(negedge clk);
    send_bits(11, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 in_reset", in_reset, 1);
    check("R1 cfg_we", cfg_we, 1);
    check("R1 tx_block", tx_block, 1);
    check("R1 bus_on", bus_on, 0);
    check("R1 ts_en/rx_en", {ts_en, rx_en}, 0);
    check("R1 tx_slot_en", tx_slot_en, 0);

    // R2 R3 vector table
    for (int v = 0; v < 6; v++) begin
      go_reset();
      sw_reset = 1'b0;
      @(negedge clk);
      check("R2 leave reset", in_reset, 0);
      check("R10 cfg_we off", cfg_we, 0);
      check("R11 joining slots", tx_slot_en, 0);
      for (int b = 0; b < int'(VEC[v][20:16]); b++) send_bits(1, VEC[v][b]);
      check("R2 R3 bus_on", bus_on, VEC[v][21]);
      check("R2 ts_en", ts_en, VEC[v][21]);
    end

    // R4 forced reset alone holds
    go_reset();
    sw_reset = 1'b0; force_reset = 1'b1;
    send_bits(12, 1'b1);
    check("R4 force holds reset", in_reset, 1);
    check("R4 force no join", bus_on, 0);
    force_reset = 1'b0;
    @(negedge clk);
    check("R4 both clear leaves", in_reset, 0);

    // R11 R9 attached
    join_bus();
    check("R11 all slots", tx_slot_en, 4'hF);
    check("R9 no block attached", tx_block, 0);
    check("R10 cfg refused", cfg_we, 0);

    // R5 R6 R9 R8 drain
    tx_pend = 4'b0011; bus_idle = 1'b0; sw_reset = 1'b1;
    @(negedge clk);
    check("R9 block on stop", tx_block, 1);
    check("R5 captured slots", tx_slot_en, 4'b0011);
    check("R6 rx kept", {rx_en, bus_on}, 2'b11);
    check("R5 not yet reset", in_reset, 0);
    tx_pend = 4'b0111;
    @(negedge clk);
    check("R5 late slot excluded", tx_slot_en, 4'b0011);
    tx_pend = 4'b0100;
    repeat (2) @(negedge clk);
    check("R5 waits for idle", in_reset, 0);
    check("R5 drained slots", tx_slot_en, 4'b0000);
    bus_idle = 1'b1;
    @(negedge clk);
    check("R5 reset after idle", in_reset, 1);
    check("R8 clear pulse", cnt_clr, 1);
    check("R6 rx off", {rx_en, bus_on}, 0);
    @(negedge clk);
    check("R8 pulse one cycle", cnt_clr, 0);

    // R7 bus-off recovery
    join_bus();
    bus_off = 1'b1; sw_reset = 1'b1;
    @(negedge clk);
    check("R7 recovery blocks tx", tx_block, 1);
    check("R7 recovery detached", bus_on, 0);
    send_bits(5, 1'b1); send_bits(1, 1'b0); send_bits(11, 1'b1);
    for (int r = 0; r < 126; r++) send_bits(11, 1'b1);
    check("R7 after 127 runs", in_reset, 0);
    send_bits(10, 1'b1); send_bits(1, 1'b0);
    check("R7 dominant mid run", in_reset, 0);
    send_bits(11, 1'b1);
    check("R7 128th run reset", in_reset, 1);
    check("R8 clear on recovery", cnt_clr, 1);
    @(negedge clk);
    check("R8 recovery pulse ends", cnt_clr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule